// File: doc/BRIEF.md
# Converter Configuration Register Bank

This block is the configuration store that sits behind a data converter's control port. It keeps sixteen 16-bit words, selected by a 4-bit address, and a plain parallel bus reads and writes them. While the unlock input is low, the bank is pinned to its power-up values and no write changes anything. Location 4'hF is a constant. Location 4'h5 holds the calibration results and can only be reached while an access-enable bit is set in location 4'h4.

From the stored words and a few pins, the bank derives the control signals the converter core uses. These are a one-cycle calibration start pulse, the power-down state of each of the two channels, the sampling-mode selection with a flag for unsupported combinations, a low-frequency select, and three delay codes that are clamped to their usable range.

Top module: `adc_cfg_regbank`

## Requirements
- R1: After reset, addresses 4'h0..4'hF hold 2000h, 2907h, 0000h, 4000h, DB4Bh, 0000h, 1C2Eh, 8142h, 0F0Fh, 0000h, 0000h, 4000h, 0004h, 0000h, 0003h, 001Dh. Address 4'h0 is the first value and 4'hF the last.
- R2: While `ctl_unlock` is low, every location is reloaded with its reset value on each clock edge, and bus writes have no effect.
- R3: Address 4'hF always reads 001Dh. A write to it changes nothing.
- R4: Address 4'h5 can be written only while bit 7 of address 4'h4 is 1. A read of 4'h5 while that bit is 0 returns 0000h.
- R5: The calibration request is bit 15 of address 4'h0 ORed with `cal_pin`, after `cal_pin` passes through two synchronizer flops. `cal_start` is a one-cycle pulse for each low-to-high transition of this request. A request that stays high gives no further pulse.
- R6: `pd_i_eff` is bit 11 of address 4'h0 ORed with `pd_i_pin`. `pd_q_eff` is bit 10 of address 4'h0 ORed with `pd_q_pin`. Both pins act whatever the state of `ctl_unlock`.
- R7: `samp_mode` is decoded from {address 4'h0 bits [7:5], address 4'hE bit 6}. The codes are: 000/0 gives 0 (single-edge), 100/0 gives 1 (dual-edge on I), 110/0 gives 2 (dual-edge on Q), 101/0 gives 3 (dual-edge with I and Q joined), and 000/1 gives 4 (dual-edge with the clock shared across I and Q).
- R8: Any other combination sets `mode_illegal` and forces `samp_mode` to 0.
- R9: When bit 3 of address 4'hC is 1, `coarse_dly` is address 4'hC bits [15:4] clamped to at most 2431, and `fine_dly` is address 4'hD bits [15:10]. When that bit is 0, both outputs are 0.
- R10: `refclk_dly` is address 4'hE bits [15:7] clamped to at most 319.
- R11: `lowfreq_eff` is bit 8 of address 4'h0 ORed with `lowrate_pin`. While the pin is high, the bit has no effect.
- R12: A read presented with `bus_rd` returns the word on `bus_rdata` with `bus_rvalid` high one clock later, in either state of `ctl_unlock`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_unlock | input | 1 | High allows register writes; low pins the bank to its reset values |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| cal_pin | input | 1 | Asynchronous calibration request pin |
| pd_i_pin | input | 1 | I channel power-down pin |
| pd_q_pin | input | 1 | Q channel power-down pin |
| lowrate_pin | input | 1 | Low-sampling-rate power-saving mode pin |
| cal_start | output | 1 | One-cycle calibration start pulse |
| pd_i_eff | output | 1 | Effective I channel power-down |
| pd_q_eff | output | 1 | Effective Q channel power-down |
| lowfreq_eff | output | 1 | Effective low-frequency select |
| samp_mode | output | 3 | Decoded sampling mode |
| mode_illegal | output | 1 | Unsupported mode combination |
| coarse_dly | output | 12 | Clamped coarse aperture delay code |
| fine_dly | output | 6 | Fine aperture delay code |
| refclk_dly | output | 9 | Clamped reference clock delay code |

## Verification
The hardest case to reach is a second calibration start. Neither the register bit nor the pin clears itself, so the bench has to walk the request through a set of overlapping states. These are: bit high, then pin also high, then bit dropped while the pin holds, then pin dropped, and only then a fresh rise. The number of pulses must stay put through every step until the last one.

The access gate on location 4'h5 is also reached through a sequence. A write is attempted while the gate is closed, the gate is then opened, the result is read back, and the gate is closed again. Each step is scored against a reference model held in the bench.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int NREGS  = 1 << ADDR_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    SMODE_SINGLE   = 3'd0,
    SMODE_DUAL_I   = 3'd1,
    SMODE_DUAL_Q   = 3'd2,
    SMODE_DUAL_IQ  = 3'd3,
    SMODE_DUAL_CLK = 3'd4
  } smode_e;

  typedef struct packed {
    smode_e mode;
    logic   bad;
  } mode_dec_t;

  // Power-up contents of each location
  function automatic word_t reset_word(input logic [ADDR_W-1:0] a);
    word_t w;
    case (a)
      4'h0:    w = 16'h2000;
      4'h1:    w = 16'h2907;
      4'h3:    w = 16'h4000;
      4'h4:    w = 16'hDB4B;
      4'h6:    w = 16'h1C2E;
      4'h7:    w = 16'h8142;
      4'h8:    w = 16'h0F0F;
      4'hB:    w = 16'h4000;
      4'hC:    w = 16'h0004;
      4'hE:    w = 16'h0003;
      4'hF:    w = 16'h001D;
      default: w = 16'h0000;
    endcase
    return w;
  endfunction

  // Sampling-mode decode: edge bits {dual, q_sel, join} plus shared-clock bit
  function automatic mode_dec_t decode_mode(input logic [2:0] edge_bits,
                                            input logic       clk_share);
    mode_dec_t d;
    d.bad = 1'b0;
    unique case ({edge_bits, clk_share})
      4'b000_0: d.mode = SMODE_SINGLE;
      4'b100_0: d.mode = SMODE_DUAL_I;
      4'b110_0: d.mode = SMODE_DUAL_Q;
      4'b101_0: d.mode = SMODE_DUAL_IQ;
      4'b000_1: d.mode = SMODE_DUAL_CLK;
      default: begin
        d.mode = SMODE_SINGLE;
        d.bad  = 1'b1;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import adc_cfg_pkg::*;
#(
  parameter int RO_ADDR    = 15,
  parameter int GATED_ADDR = 5,
  parameter int GATE_REG   = 4,
  parameter int GATE_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_unlock,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wdata,
  input  logic              wr,
  input  logic              rd,
  output word_t             rdata,
  output logic              rvalid,
  output word_t             regs_o [NREGS],
  output logic              acc_en_o,
  output logic              wr_accept_o
);

  word_t regs_q [NREGS];
  logic  acc_en;
  logic  write_ok;

  assign acc_en   = regs_q[GATE_REG][GATE_BIT];
  assign write_ok = wr && ctl_unlock
                    && (addr != ADDR_W'(RO_ADDR))
                    && ((addr != ADDR_W'(GATED_ADDR)) || acc_en);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == RO_ADDR) begin : g_ro
      assign regs_q[i] = reset_word(ADDR_W'(i));
    end else begin : g_rw
      logic hit;
      assign hit = write_ok && (addr == ADDR_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n || !ctl_unlock) begin
          regs_q[i] <= reset_word(ADDR_W'(i));
        end else if (hit) begin
          regs_q[i] <= wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) begin
        if ((addr == ADDR_W'(GATED_ADDR)) && !acc_en) begin
          rdata <= '0;
        end else begin
          rdata <= regs_q[addr];
        end
      end
    end
  end

  assign regs_o      = regs_q;
  assign acc_en_o    = acc_en;
  assign wr_accept_o = write_ok;

endmodule

// File: rtl/cfg_cal_trigger.sv
module cfg_cal_trigger #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_bit,
  input  logic cal_pin,
  output logic cal_req,
  output logic cal_start
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cal_pin};
    end
  end

  assign cal_req = cal_bit | sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      cal_start <= 1'b0;
    end else begin
      req_q     <= cal_req;
      cal_start <= cal_req & ~req_q;
    end
  end

endmodule

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
  import adc_cfg_pkg::*;
(
  input  logic [2:0] edge_bits,
  input  logic       clk_share,
  output smode_e     mode,
  output logic       illegal
);

  mode_dec_t dec;

  always_comb begin
    dec     = decode_mode(edge_bits, clk_share);
    mode    = dec.mode;
    illegal = dec.bad;
  end

endmodule

// File: rtl/cfg_delay_map.sv
module cfg_delay_map #(
  parameter int CAM_W   = 12,
  parameter int CAM_MAX = 2431,
  parameter int FAM_W   = 6,
  parameter int DRC_W   = 9,
  parameter int DRC_MAX = 319
) (
  input  logic [CAM_W-1:0] cam_raw,
  input  logic [FAM_W-1:0] fam_raw,
  input  logic             adj_en,
  input  logic [DRC_W-1:0] drc_raw,
  output logic [CAM_W-1:0] cam_out,
  output logic [FAM_W-1:0] fam_out,
  output logic [DRC_W-1:0] drc_out
);

  localparam logic [CAM_W-1:0] CAM_LIM = CAM_W'(CAM_MAX);
  localparam logic [DRC_W-1:0] DRC_LIM = DRC_W'(DRC_MAX);

  function automatic logic [CAM_W-1:0] clamp_cam(input logic [CAM_W-1:0] v);
    return (v > CAM_LIM) ? CAM_LIM : v;
  endfunction

  function automatic logic [DRC_W-1:0] clamp_drc(input logic [DRC_W-1:0] v);
    return (v > DRC_LIM) ? DRC_LIM : v;
  endfunction

  always_comb begin
    cam_out = adj_en ? clamp_cam(cam_raw) : '0;
    fam_out = adj_en ? fam_raw : '0;
    drc_out = clamp_drc(drc_raw);
  end

endmodule

// File: rtl/adc_cfg_regbank.sv
module adc_cfg_regbank
  import adc_cfg_pkg::*;
#(
  parameter int CAL_SYNC = 2,
  parameter int CAM_W    = 12,
  parameter int CAM_MAX  = 2431,
  parameter int FAM_W    = 6,
  parameter int DRC_W    = 9,
  parameter int DRC_MAX  = 319
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_unlock,
  input  logic [3:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              cal_pin,
  input  logic              pd_i_pin,
  input  logic              pd_q_pin,
  input  logic              lowrate_pin,
  output logic              cal_start,
  output logic              pd_i_eff,
  output logic              pd_q_eff,
  output logic              lowfreq_eff,
  output logic [2:0]        samp_mode,
  output logic              mode_illegal,
  output logic [CAM_W-1:0]  coarse_dly,
  output logic [FAM_W-1:0]  fine_dly,
  output logic [DRC_W-1:0]  refclk_dly
);

  // Locations and fields the decoders depend on
  localparam int A_MAIN   = 0;
  localparam int A_CALADJ = 4;
  localparam int A_CALVAL = 5;
  localparam int A_CDLY   = 12;
  localparam int A_FDLY   = 13;
  localparam int A_SYNC   = 14;
  localparam int A_CONST  = 15;

  localparam int B_CAL    = 15;
  localparam int B_PDI    = 11;
  localparam int B_PDQ    = 10;
  localparam int B_LFS    = 8;
  localparam int B_EDGE_H = 7;
  localparam int B_EDGE_L = 5;
  localparam int B_GATE   = 7;
  localparam int B_ADJEN  = 3;
  localparam int B_SHARE  = 6;

  word_t  regs [NREGS];
  logic   acc_en;
  logic   wr_accept;
  logic   cal_req;
  word_t  word0;
  smode_e mode_dec;

  cfg_reg_store #(
    .RO_ADDR    (A_CONST),
    .GATED_ADDR (A_CALVAL),
    .GATE_REG   (A_CALADJ),
    .GATE_BIT   (B_GATE)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_unlock  (ctl_unlock),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .wr          (bus_wr),
    .rd          (bus_rd),
    .rdata       (bus_rdata),
    .rvalid      (bus_rvalid),
    .regs_o      (regs),
    .acc_en_o    (acc_en),
    .wr_accept_o (wr_accept)
  );

  assign word0 = regs[A_MAIN];

  cfg_cal_trigger #(
    .SYNC_STAGES (CAL_SYNC)
  ) u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_bit   (word0[B_CAL]),
    .cal_pin   (cal_pin),
    .cal_req   (cal_req),
    .cal_start (cal_start)
  );

  cfg_mode_decode u_mode (
    .edge_bits (word0[B_EDGE_H:B_EDGE_L]),
    .clk_share (regs[A_SYNC][B_SHARE]),
    .mode      (mode_dec),
    .illegal   (mode_illegal)
  );

  assign samp_mode = mode_dec;

  cfg_delay_map #(
    .CAM_W   (CAM_W),
    .CAM_MAX (CAM_MAX),
    .FAM_W   (FAM_W),
    .DRC_W   (DRC_W),
    .DRC_MAX (DRC_MAX)
  ) u_dly (
    .cam_raw (regs[A_CDLY][WORD_W-1 -: CAM_W]),
    .fam_raw (regs[A_FDLY][WORD_W-1 -: FAM_W]),
    .adj_en  (regs[A_CDLY][B_ADJEN]),
    .drc_raw (regs[A_SYNC][WORD_W-1 -: DRC_W]),
    .cam_out (coarse_dly),
    .fam_out (fine_dly),
    .drc_out (refclk_dly)
  );

  assign pd_i_eff    = word0[B_PDI] | pd_i_pin;
  assign pd_q_eff    = word0[B_PDQ] | pd_q_pin;
  assign lowfreq_eff = word0[B_LFS] | lowrate_pin;

endmodule

// File: rtl/adc_cfg_regbank_chk.sv
module adc_cfg_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_unlock,
  input logic [3:0]  bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [15:0] bus_rdata,
  input logic        cal_start,
  input logic        cal_req,
  input logic        pd_i_pin,
  input logic        pd_i_eff,
  input logic        pd_q_pin,
  input logic        pd_q_eff,
  input logic        lowrate_pin,
  input logic        lowfreq_eff,
  input logic [2:0]  samp_mode,
  input logic        mode_illegal,
  input logic [11:0] coarse_dly,
  input logic [8:0]  refclk_dly,
  input logic        acc_en,
  input logic        wr_accept,
  input logic [15:0] word0
);

  // R2: a locked cycle leaves location 0 at its reset value
  a_r2_locked_default: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_unlock |=> (word0 == 16'h2000));

  // R2: no write is taken while locked
  a_r2_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !ctl_unlock) |-> !wr_accept);

  // R3
  a_r3_const_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'hF) |=> (bus_rdata == 16'h001D));

  // R4
  a_r4_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'h5 && !acc_en) |=> (bus_rdata == 16'h0000));

  // R5: the pulse lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  // R5: a request that stays high gives no pulse
  a_r5_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cal_req) && cal_req) |=> !cal_start);

  // R6
  a_r6_pin_i: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i_pin |-> pd_i_eff);
  a_r6_pin_q: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q_pin |-> pd_q_eff);

  // R7: only the five mode codes appear
  a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    samp_mode <= 3'd4);

  // R8
  a_r8_illegal_single: assert property (@(posedge clk) disable iff (!rst_n)
    mode_illegal |-> (samp_mode == 3'd0));

  // R9
  a_r9_coarse_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_dly <= 12'd2431);

  // R10
  a_r10_ref_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    refclk_dly <= 9'd319);

  // R11
  a_r11_lowrate_forces: assert property (@(posedge clk) disable iff (!rst_n)
    lowrate_pin |-> lowfreq_eff);

endmodule

bind adc_cfg_regbank adc_cfg_regbank_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_unlock   (ctl_unlock),
  .bus_addr     (bus_addr),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_rdata    (bus_rdata),
  .cal_start    (cal_start),
  .cal_req      (cal_req),
  .pd_i_pin     (pd_i_pin),
  .pd_i_eff     (pd_i_eff),
  .pd_q_pin     (pd_q_pin),
  .pd_q_eff     (pd_q_eff),
  .lowrate_pin  (lowrate_pin),
  .lowfreq_eff  (lowfreq_eff),
  .samp_mode    (samp_mode),
  .mode_illegal (mode_illegal),
  .coarse_dly   (coarse_dly),
  .refclk_dly   (refclk_dly),
  .acc_en       (acc_en),
  .wr_accept    (wr_accept),
  .word0        (word0)
);

// File: tb/adc_cfg_regbank_tb_top.sv
module adc_cfg_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_unlock = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        cal_pin = 1'b0;
  logic        pd_i_pin = 1'b0;
  logic        pd_q_pin = 1'b0;
  logic        lowrate_pin = 1'b0;
  logic        cal_start;
  logic        pd_i_eff;
  logic        pd_q_eff;
  logic        lowfreq_eff;
  logic [2:0]  samp_mode;
  logic        mode_illegal;
  logic [11:0] coarse_dly;
  logic [5:0]  fine_dly;
  logic [8:0]  refclk_dly;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done   = 1'b0;

  logic [15:0] model [16];
  logic [15:0] exp_q [$];

  always #5 clk = ~clk;

  adc_cfg_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_unlock(ctl_unlock),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cal_pin(cal_pin), .pd_i_pin(pd_i_pin), .pd_q_pin(pd_q_pin),
    .lowrate_pin(lowrate_pin), .cal_start(cal_start),
    .pd_i_eff(pd_i_eff), .pd_q_eff(pd_q_eff), .lowfreq_eff(lowfreq_eff),
    .samp_mode(samp_mode), .mode_illegal(mode_illegal),
    .coarse_dly(coarse_dly), .fine_dly(fine_dly), .refclk_dly(refclk_dly)
  );

  // R1 reset values, restated from the requirement
  function automatic logic [15:0] dflt(input int a);
    logic [15:0] t [16] = '{16'h2000, 16'h2907, 16'h0000, 16'h4000,
                            16'hDB4B, 16'h0000, 16'h1C2E, 16'h8142,
                            16'h0F0F, 16'h0000, 16'h0000, 16'h4000,
                            16'h0004, 16'h0000, 16'h0003, 16'h001D};
    return t[a];
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 16; a++) model[a] = dflt(a);
  endtask

  task automatic check(input bit ok, input string tag,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver tasks: start and end on a falling edge
  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    if (ctl_unlock && a != 4'hF && !(a == 4'h5 && !model[4][7]))
      model[a] = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    exp_q.push_back((a == 4'h5 && !model[4][7]) ? 16'h0000 : model[a]);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_unlock(input bit v);
    ctl_unlock = v;
    @(posedge clk);
    if (!v) model_reset();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: scores every returned read (R12 latency, R1..R4 contents)
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected rvalid", bus_rdata, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(bus_rdata == e, "R12 read data", bus_rdata, e);
      end
    end
    if (rst_n && cal_start) pulses++;
  end

  function automatic int exp_mode(input logic [3:0] k, output bit bad);
    bad = 1'b0;
    if (k == 4'b1000) return 1;
    if (k == 4'b1100) return 2;
    if (k == 4'b1010) return 3;
    if (k == 4'b0001) return 4;
    if (k == 4'b0000) return 0;
    bad = 1'b1;
    return 0;
  endfunction

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1: every location after reset, bank locked
    for (int a = 0; a < 16; a++) rd_reg(4'(a));
    idle(2);
    check(pulses == 0, "R5 no pulse after reset", pulses, 0);

    // R12: reads work while unlocked; writes land
    set_unlock(1'b1);
    wr_reg(4'h2, 16'h1ABC);
    rd_reg(4'h2);
    wr_reg(4'hA, 16'h0F55);
    rd_reg(4'hA);

    // R3: constant location ignores writes
    wr_reg(4'hF, 16'hFFFF);
    rd_reg(4'hF);

    // R4: gate closed, write dropped, read zero; open, write, read; close
    wr_reg(4'h5, 16'h1234);
    rd_reg(4'h5);
    wr_reg(4'h4, 16'hDBCB);
    rd_reg(4'h5);
    wr_reg(4'h5, 16'h1234);
    rd_reg(4'h5);
    wr_reg(4'h4, 16'hDB4B);
    rd_reg(4'h5);
    idle(2);

    // R2: locking restores defaults, writes ignored
    set_unlock(1'b0);
    rd_reg(4'h2);
    rd_reg(4'h4);
    wr_reg(4'h2, 16'h5555);
    rd_reg(4'h2);
    wr_reg(4'h0, 16'h0800);
    check(pd_i_eff == 1'b0, "R2 locked write ignored pd_i", pd_i_eff, 0);

    // R6: pins act while locked
    pd_i_pin = 1'b1; #1;
    check(pd_i_eff == 1'b1 && pd_q_eff == 1'b0, "R6 pin I locked",
          {pd_i_eff, pd_q_eff}, 2'b10);
    pd_i_pin = 1'b0; pd_q_pin = 1'b1; #1;
    check(pd_q_eff == 1'b1 && pd_i_eff == 1'b0, "R6 pin Q locked",
          {pd_i_eff, pd_q_eff}, 2'b01);
    pd_q_pin = 1'b0;
    idle(1);
    set_unlock(1'b1);
    wr_reg(4'h0, 16'h2C00);
    check(pd_i_eff && pd_q_eff, "R6 register bits", {pd_i_eff, pd_q_eff}, 2'b11);
    wr_reg(4'h0, 16'h2000);
    check(!pd_i_eff && !pd_q_eff, "R6 released", {pd_i_eff, pd_q_eff}, 2'b00);

    // R11: low-frequency select
    check(lowfreq_eff == 1'b0, "R11 both low", lowfreq_eff, 0);
    lowrate_pin = 1'b1; #1;
    check(lowfreq_eff == 1'b1, "R11 pin forces", lowfreq_eff, 1);
    lowrate_pin = 1'b0;
    wr_reg(4'h0, 16'h2100);
    check(lowfreq_eff == 1'b1, "R11 bit", lowfreq_eff, 1);
    wr_reg(4'h0, 16'h2000);

    // R7 / R8: every combination of the four mode bits
    for (int k = 0; k < 16; k++) begin
      bit bad;
      int em;
      wr_reg(4'h0, 16'h2000 | 16'((k >> 1) << 5));
      wr_reg(4'hE, 16'h0003 | 16'((k & 1) << 6));
      em = exp_mode(4'(k), bad);
      check(samp_mode == 3'(em), bad ? "R8 forced mode" : "R7 mode",
            samp_mode, em);
      check(mode_illegal == bad, "R8 illegal flag", mode_illegal, bad);
    end
    wr_reg(4'h0, 16'h2000);

    // R9: aperture delays
    wr_reg(4'hC, 16'h9808);
    check(coarse_dly == 12'd2431, "R9 coarse 2432 clamps", coarse_dly, 2431);
    wr_reg(4'hC, 16'h97F8);
    check(coarse_dly == 12'd2431, "R9 coarse 2431", coarse_dly, 2431);
    wr_reg(4'hC, 16'hFFF8);
    check(coarse_dly == 12'd2431, "R9 coarse max clamps", coarse_dly, 2431);
    wr_reg(4'hC, 16'h1238);
    check(coarse_dly == 12'h123, "R9 coarse pass", coarse_dly, 12'h123);
    wr_reg(4'hD, 16'hFC00);
    check(fine_dly == 6'd63, "R9 fine enabled", fine_dly, 63);
    wr_reg(4'hC, 16'h1230);
    check(coarse_dly == 0 && fine_dly == 0, "R9 disabled zero",
          {coarse_dly, fine_dly}, 0);

    // R10: reference clock delay
    wr_reg(4'hE, 16'((318 << 7) | 3));
    check(refclk_dly == 9'd318, "R10 below limit", refclk_dly, 318);
    wr_reg(4'hE, 16'((319 << 7) | 3));
    check(refclk_dly == 9'd319, "R10 at limit", refclk_dly, 319);
    wr_reg(4'hE, 16'((320 << 7) | 3));
    check(refclk_dly == 9'd319, "R10 clamp 320", refclk_dly, 319);
    wr_reg(4'hE, 16'hFF83);
    check(refclk_dly == 9'd319, "R10 clamp 511", refclk_dly, 319);

    // R5: calibration request walk
    begin
      int p0;
      p0 = pulses;
      wr_reg(4'h0, 16'hA000);
      idle(4);
      check(pulses == p0 + 1, "R5 bit rise", pulses, p0 + 1);
      cal_pin = 1'b1;
      idle(5);
      check(pulses == p0 + 1, "R5 pin while high", pulses, p0 + 1);
      wr_reg(4'h0, 16'h2000);
      idle(4);
      check(pulses == p0 + 1, "R5 bit drop pin held", pulses, p0 + 1);
      cal_pin = 1'b0;
      idle(5);
      check(pulses == p0 + 1, "R5 both low", pulses, p0 + 1);
      cal_pin = 1'b1;
      idle(5);
      check(pulses == p0 + 2, "R5 pin fresh rise", pulses, p0 + 2);
      cal_pin = 1'b0;
      idle(5);
      wr_reg(4'h0, 16'hA000);
      idle(4);
      check(pulses == p0 + 3, "R5 bit fresh rise", pulses, p0 + 3);
      wr_reg(4'h0, 16'h2000);
    end

    idle(3);
    check(exp_q.size() == 0, "R12 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule